// File: doc/BRIEF.md
# Per-Channel Edge Interrupt Collector

This block turns a word of already-debounced digital inputs into one interrupt request. Every channel has its own polarity setting, which picks whether a low-to-high or a high-to-low transition counts as an event. It also has its own enable setting, which decides whether that channel may take part at all. An event on an enabled channel sets a sticky status bit. The interrupt line is the OR of all sticky bits.

Software works through a small register window with three locations. It sets the polarity word and the enable word, then services an interrupt by reading the status word. That read returns the pending channels and clears them in the same access. An event that lands in the same cycle as the clearing read is kept, so no transition is lost between two services.

Top module: `edge_irq_collect`

## Requirements
- R1: After reset the polarity word, the enable word and the status word all read as zero, and `irq` is low.
- R2: A write to offset 0x10 loads the polarity word and a write to offset 0x14 loads the enable word. A read of either offset returns the last value written. A read of any other unmapped offset returns zero.
- R3: With polarity bit n at 0 and enable bit n at 1, a 0-to-1 change on input n sets status bit n at the first clock edge that samples the new level.
- R4: With polarity bit n at 1 and enable bit n at 1, a 1-to-0 change on input n sets status bit n at the first clock edge that samples the new level.
- R5: A transition on channel n while enable bit n is 0 never sets status bit n. Setting the enable bit afterwards does not bring that transition back.
- R6: `irq` is high exactly when at least one status bit is set.
- R7: A read at offset 0x20 returns the status word, bit n being 1 when channel n has fired. The clock edge that ends the read clears every bit it returned.
- R8: An enabled event that occurs in the same cycle as a status read is still latched after that read's clear.
- R9: A transition in the direction opposite to the channel's polarity setting does not set its status bit.
- R10: Several channels firing in the same cycle each set their own status bit, independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inBits | input | NUM_CH | Debounced channel levels |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wrData | input | NUM_CH | Write data |
| rdData | output | NUM_CH | Read data, valid in the cycle of `rdEn` |
| irq | output | 1 | Combined interrupt request |

## Verification
Directed sequences first drive each polarity setting with both transition directions. This separates R3, R4 and R9: a polarity decode that is swapped or ignored fires on the wrong edge. A channel that is toggled while disabled and then enabled checks that events are discarded, not held back until the enable. A status read placed on the same cycle as a new event shows whether the clear overwrites fresh events. Multi-bit bursts check that channels do not mix. Seeded random toggling, random reads and random reconfiguration then compare `irq` and every read value against a bench model in every cycle, which finds ordering faults that the directed cases do not reach.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef struct packed {
    logic wrPolarity;
    logic wrEnable;
    logic rdStatus;
  } regStrobeT;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_POLAR  = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_STATUS = 2'd3
  } rdSelT;

endpackage

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned POLAR_OFS  = 'h10,
  parameter int unsigned ENABLE_OFS = 'h14,
  parameter int unsigned STATUS_OFS = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobeT         strobe,
  output rdSelT             rdSel
);

  localparam logic [ADDR_W-1:0] POLAR_A  = ADDR_W'(POLAR_OFS);
  localparam logic [ADDR_W-1:0] ENABLE_A = ADDR_W'(ENABLE_OFS);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

  logic hitPolar, hitEnable, hitStatus;

  always_comb begin
    hitPolar  = (addr == POLAR_A);
    hitEnable = (addr == ENABLE_A);
    hitStatus = (addr == STATUS_A);

    strobe.wrPolarity = wrEn & hitPolar;
    strobe.wrEnable   = wrEn & hitEnable;
    strobe.rdStatus   = rdEn & hitStatus;

    rdSel = SEL_NONE;
    if (rdEn) begin
      if (hitPolar)       rdSel = SEL_POLAR;
      else if (hitEnable) rdSel = SEL_ENABLE;
      else if (hitStatus) rdSel = SEL_STATUS;
    end
  end

  // R2: one access decodes to at most one register action
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrPolarity, strobe.wrEnable, strobe.rdStatus}));

  // R7: a clearing read only comes with the status read path selected
  a_r7_clear_with_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStatus |-> (rdSel == SEL_STATUS));

endmodule

// File: rtl/edge_irq_datapath.sv
module edge_irq_datapath
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] inBits,
  input  logic [NUM_CH-1:0] wrData,
  input  regStrobeT         strobe,
  input  rdSelT             rdSel,
  output logic [NUM_CH-1:0] rdData,
  output logic              irq
);

  logic [NUM_CH-1:0] polarQ;
  logic [NUM_CH-1:0] enableQ;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] prevQ;
  logic [NUM_CH-1:0] evt;
  logic [NUM_CH-1:0] evtLive;
  logic [NUM_CH-1:0] keepMask;

  // per-channel transition detector, polarity chosen bit by bit
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic rise, fall;
    always_comb begin
      rise    = inBits[ch] & ~prevQ[ch];
      fall    = ~inBits[ch] & prevQ[ch];
      evt[ch] = polarQ[ch] ? fall : rise;
    end
  end

  always_comb begin
    evtLive  = evt & enableQ;
    keepMask = strobe.rdStatus ? '0 : statusQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polarQ  <= '0;
      enableQ <= '0;
      statusQ <= '0;
      prevQ   <= '0;
    end else begin
      prevQ   <= inBits;
      statusQ <= keepMask | evtLive;
      if (strobe.wrPolarity) polarQ  <= wrData;
      if (strobe.wrEnable)   enableQ <= wrData;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_POLAR:  rdData = polarQ;
      SEL_ENABLE: rdData = enableQ;
      SEL_STATUS: rdData = statusQ;
      default:    rdData = '0;
    endcase
  end

  assign irq = |statusQ;

  // R5: a newly set status bit always belonged to an enabled channel
  a_r5_masked_no_set: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) & ~$past(enableQ)) == '0);

  // R3: a newly set status bit always comes from a detected transition
  a_r3_set_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) & ~$past(evt)) == '0);

  // R7: after a clearing read only the events of that cycle remain
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStatus |=> ((statusQ & ~$past(evtLive)) == '0));

  // R8: an event coinciding with the clearing read survives it
  a_r8_keep_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStatus && (evtLive != '0)) |=> irq);

  // R6: the request can only start after an enabled event
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(evtLive) != '0));

endmodule

// File: rtl/edge_irq_collect.sv
module edge_irq_collect
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] inBits,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] wrData,
  output logic [NUM_CH-1:0] rdData,
  output logic              irq
);

  regStrobeT strobe;
  rdSelT     rdSel;

  edge_irq_ctrl #(
    .ADDR_W    (ADDR_W),
    .POLAR_OFS ('h10),
    .ENABLE_OFS('h14),
    .STATUS_OFS('h20)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .strobe(strobe),
    .rdSel (rdSel)
  );

  edge_irq_datapath #(
    .NUM_CH(NUM_CH)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .inBits(inBits),
    .wrData(wrData),
    .strobe(strobe),
    .rdSel (rdSel),
    .rdData(rdData),
    .irq   (irq)
  );

endmodule

// File: tb/test_edge_irq_collect.sv
module test_edge_irq_collect;

  localparam int NCH = 32;
  localparam logic [7:0] A_POL = 8'h10;
  localparam logic [7:0] A_ENA = 8'h14;
  localparam logic [7:0] A_STA = 8'h20;
  localparam logic [7:0] A_BAD = 8'h04;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] inBits = '0;
  logic           wrEn = 1'b0;
  logic           rdEn = 1'b0;
  logic [7:0]     addr = '0;
  logic [NCH-1:0] wrData = '0;
  logic [NCH-1:0] rdData;
  logic           irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [NCH-1:0] mPol = '0, mEna = '0, mSta = '0, mPrev = '0;

  edge_irq_collect i_edge_irq_collect (
    .clk(clk), .rstN(rstN), .inBits(inBits), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [NCH-1:0] expEvents(logic [NCH-1:0] pol, logic [NCH-1:0] ena,
                                               logic [NCH-1:0] prev, logic [NCH-1:0] cur);
    return ((~pol & cur & ~prev) | (pol & ~cur & prev)) & ena;
  endfunction

  function automatic logic [NCH-1:0] expRead(logic [7:0] a);
    if (a == A_POL) return mPol;
    if (a == A_ENA) return mEna;
    if (a == A_STA) return mSta;
    return '0;
  endfunction

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op: 0 idle, 1 write, 2 read
  task automatic cycle(string req, logic [NCH-1:0] nIn, int op, logic [7:0] a, logic [NCH-1:0] d);
    logic [NCH-1:0] ev;
    @(negedge clk);
    inBits = nIn;
    wrEn   = (op == 1);
    rdEn   = (op == 2);
    addr   = a;
    wrData = d;
    #5;
    check({req, " R6 irq"}, {31'd0, irq}, {31'd0, |mSta});
    if (op == 2) check({req, " read"}, rdData, expRead(a));
    @(posedge clk);
    ev = expEvents(mPol, mEna, mPrev, nIn);
    mSta  = ((op == 2 && a == A_STA) ? '0 : mSta) | ev;
    mPrev = nIn;
    if (op == 1 && a == A_POL) mPol = d;
    if (op == 1 && a == A_ENA) mEna = d;
    #1;
    wrEn = 1'b0;
    rdEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [NCH-1:0] cur;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    cycle("R1 polarity", '0, 2, A_POL, '0);
    cycle("R1 enable", '0, 2, A_ENA, '0);
    cycle("R1 status", '0, 2, A_STA, '0);
    check("R1 irq low", {31'd0, irq}, '0);

    // R2 write and readback, unmapped read
    cycle("R2 wr pol", '0, 1, A_POL, 32'hA5A5_0F0F);
    cycle("R2 rd pol", '0, 2, A_POL, '0);
    cycle("R2 wr ena", '0, 1, A_ENA, 32'h1234_5678);
    cycle("R2 rd ena", '0, 2, A_ENA, '0);
    cycle("R2 rd unmapped", '0, 2, A_BAD, '0);
    cycle("R2 clr pol", '0, 1, A_POL, '0);
    cycle("R2 all ena", '0, 1, A_ENA, '1);

    // R3 rising edge on channel 3, R7 read clears
    cycle("R3 rise", 32'h8, 0, A_BAD, '0);
    check("R3 irq after rise", {31'd0, irq}, 32'd1);
    cycle("R7 read", 32'h8, 2, A_STA, '0);
    cycle("R7 cleared", 32'h8, 2, A_STA, '0);
    check("R7 irq low after clear", {31'd0, irq}, '0);

    // R9 opposite edge (fall on rising channel) ignored
    cycle("R9 fall ignored", '0, 0, A_BAD, '0);
    cycle("R9 status", '0, 2, A_STA, '0);

    // R4 falling polarity on channel 5, rise ignored (R9) then fall fires
    cycle("R4 set pol", '0, 1, A_POL, 32'h20);
    cycle("R9 rise on falling ch", 32'h20, 0, A_BAD, '0);
    cycle("R9 status empty", 32'h20, 2, A_STA, '0);
    cycle("R4 fall", '0, 0, A_BAD, '0);
    cycle("R4 status", '0, 2, A_STA, '0);

    // R5 masked channel 7 toggles, then unmask, nothing latched
    cycle("R5 mask", '0, 1, A_ENA, ~32'h80);
    cycle("R5 rise masked", 32'h80, 0, A_BAD, '0);
    cycle("R5 fall masked", '0, 0, A_BAD, '0);
    cycle("R5 rise masked2", 32'h80, 0, A_BAD, '0);
    cycle("R5 unmask", 32'h80, 1, A_ENA, '1);
    cycle("R5 idle", 32'h80, 0, A_BAD, '0);
    cycle("R5 status", 32'h80, 2, A_STA, '0);

    // R8 event in same cycle as read survives
    cycle("R8 prep", 32'h80, 0, A_BAD, '0);
    cycle("R8 pending", 32'h81, 0, A_BAD, '0);
    cycle("R8 read with event", 32'h281, 2, A_STA, '0);
    check("R8 irq kept", {31'd0, irq}, 32'd1);
    cycle("R8 survivor", 32'h281, 2, A_STA, '0);

    // R10 many channels at once
    cycle("R10 burst", 32'h0F0F_FA81, 0, A_BAD, '0);
    cycle("R10 status", 32'h0F0F_FA81, 2, A_STA, '0);

    // random phase
    void'($urandom(32'd1234));
    cur = 32'h0F0F_FA81;
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cur = cur ^ ($urandom() & $urandom());
      if (r == 0)      cycle("R3/R4 rand pol", cur, 1, A_POL, $urandom());
      else if (r == 1) cycle("R5 rand ena", cur, 1, A_ENA, $urandom());
      else if (r < 4)  cycle("R7/R8 rand read", cur, 2, A_STA, '0);
      else if (r == 4) cycle("R2 rand readback", cur, 2, ($urandom_range(0, 1) != 0) ? A_POL : A_ENA, '0);
      else             cycle("R10 rand", cur, 0, A_BAD, '0);
    end

    finish();
  end

endmodule